// File: doc/BRIEF.md
# Byte-Parity Memory Controller with Read-Modify-Write

This block sits between one 32-bit bus master and a synchronous memory whose words are 36 bits wide: 32 data bits plus one even-parity bit for each byte. Writes receive freshly computed parity. Reads fetch the whole word and recompute its parity. A mismatch is reported only on the byte lanes that the access actually touched. The first failing access is recorded in a sticky status. That status drives an interrupt line, which a separate enable input can mask.

An aligned long-word write goes to memory in one cycle. Byte writes, word writes and unaligned writes first fetch the stored word. They then write back only the selected bytes, keep the old parity bits of the bytes they did not write, and store all four parity bits again. Every accepted access ends with a one-cycle termination strobe. An access that would cross the 32-bit word boundary is refused with an error strobe. An error-injection input corrupts the parity of the bytes being written, so that the checker can be exercised. A request is taken only while the controller is idle.

Top module: `parity_mem_ctrl`

## Requirements
- R1: Every stored byte carries an even-parity bit equal to the XOR of its eight data bits. A word written without injection reads back with no parity error.
- R2: Byte offset is addr[1:0]. Size 2'b00 selects one byte lane, 2'b01 two lanes, and 2'b10 four lanes, starting at that offset. Data uses native lanes: the byte at offset k is on bits 8k+7..8k of wdata and rdata. On a read, rdata carries the whole stored 32-bit word while term is high.
- R3: A read accepted at a clock edge asserts term during the second cycle after that edge.
- R4: A parity mismatch is recorded only if it falls in a lane that the read selects. Writes never record parity errors.
- R5: The status (sts_valid, the failing byte address sts_addr, and the mismatching selected lanes sts_lanes, with bit i meaning lane i) is set only from an idle status. Later errors leave it unchanged until it is cleared.
- R6: irq is high exactly while sts_valid and irq_en are both high.
- R7: A long-word write at offset 0 replaces the whole word and asserts term during the second cycle after acceptance.
- R8: Any other accepted write asserts term during the third cycle after acceptance. It changes only the selected bytes, and the unselected bytes keep both their data and their stored parity bits.
- R9: When inj_par is high at acceptance of a write, the stored parity bits of the written lanes are inverted, and no other parity bit is affected.
- R10: A request with size 2'b11, or whose lanes would pass byte offset 3, gives a one-cycle err pulse in the cycle after the request. It produces no term and leaves memory unchanged.
- R11: Requests presented while an access is in progress are ignored.
- R12: term lasts exactly one cycle and is never high together with err.
- R13: A high sts_clr while idle clears the status and drops irq at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, sampled in idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW+2 | Byte address |
| size | input | 2 | 00 byte, 01 word, 10 long-word |
| wdata | input | 32 | Write data in native lanes |
| inj_par | input | 1 | Invert the parity of the written lanes |
| irq_en | input | 1 | Interrupt enable |
| sts_clr | input | 1 | Write-one-to-clear for the status |
| rdata | output | 32 | Read data, valid with term |
| term | output | 1 | Cycle completion strobe |
| err | output | 1 | Rejected-access strobe |
| irq | output | 1 | Parity interrupt |
| sts_valid | output | 1 | Status holds a recorded error |
| sts_addr | output | AW+2 | Byte address of the recorded error |
| sts_lanes | output | 4 | Mismatching selected lanes |

## Verification
The bench builds the controller with AW = 4, which gives 16 memory words. Thousands of random accesses therefore land repeatedly on the same few words. That lets partial writes pile up on top of earlier injected corruption, so mixes of good and bad parity lanes inside one word are reached often. The small address space also makes overlapping sticky-status events and refused boundary-crossing requests frequent, next to the directed cases.

// File: rtl/parity_mem_ctrl.sv
module parity_mem_ctrl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW+1:0] addr,
  input  logic [1:0]    size,
  input  logic [31:0]   wdata,
  input  logic          inj_par,
  input  logic          irq_en,
  input  logic          sts_clr,
  output logic [31:0]   rdata,
  output logic          term,
  output logic          err,
  output logic          irq,
  output logic          sts_valid,
  output logic [AW+1:0] sts_addr,
  output logic [3:0]    sts_lanes
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {IDLE, READ, RMW_READ, WRITE, TERM} state_t;
  state_t st;

  logic [35:0]   mem [DEPTH];
  logic [35:0]   rd_q;
  logic [AW+1:0] a_addr;
  logic [3:0]    a_lanes;
  logic          a_we, a_inj;
  logic [31:0]   a_wdata;

  logic [2:0] nbytes;
  logic [3:0] base_mask, lanes;
  logic       bad;

  assign nbytes    = (size == 2'b00) ? 3'd1 : (size == 2'b01) ? 3'd2 : 3'd4;
  assign base_mask = (size == 2'b00) ? 4'b0001 : (size == 2'b01) ? 4'b0011 : 4'b1111;
  assign lanes     = base_mask << addr[1:0];
  assign bad       = (size == 2'b11) || (({1'b0, addr[1:0]} + nbytes) > 3'd4);

  function automatic logic [3:0] gen_par(input logic [31:0] d);
    for (int i = 0; i < 4; i++) gen_par[i] = ^d[8*i +: 8];
  endfunction

  logic [31:0] new_data;
  logic [3:0]  new_par, fresh_par, chk_fail;

  assign fresh_par = gen_par(a_wdata) ^ {4{a_inj}};
  always_comb
    for (int i = 0; i < 4; i++) begin
      new_data[8*i +: 8] = a_lanes[i] ? a_wdata[8*i +: 8] : rd_q[8*i +: 8];
      new_par[i]         = a_lanes[i] ? fresh_par[i]      : rd_q[32+i];
    end

  assign chk_fail = a_lanes & (rd_q[35:32] ^ gen_par(rd_q[31:0]));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= IDLE;
      a_addr  <= '0;
      a_lanes <= '0;
      a_we    <= 1'b0;
      a_inj   <= 1'b0;
      a_wdata <= '0;
      err     <= 1'b0;
    end else begin
      err <= (st == IDLE) && req && bad;
      case (st)
        IDLE:
          if (req && !bad) begin
            a_addr  <= addr;
            a_lanes <= lanes;
            a_we    <= we;
            a_inj   <= inj_par;
            a_wdata <= wdata;
            if (!we)                 st <= READ;
            else if (lanes == 4'hF)  st <= WRITE;
            else                     st <= RMW_READ;
          end
        READ:     st <= TERM;
        RMW_READ: st <= WRITE;
        WRITE:    st <= TERM;
        default:  st <= IDLE;
      endcase
    end

  always_ff @(posedge clk) begin
    if (st == READ || st == RMW_READ) rd_q <= mem[a_addr[AW+1:2]];
    if (st == WRITE) mem[a_addr[AW+1:2]] <= {new_par, new_data};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sts_valid <= 1'b0;
      sts_addr  <= '0;
      sts_lanes <= '0;
    end else if (st == TERM && !a_we && |chk_fail && !sts_valid) begin
      sts_valid <= 1'b1;
      sts_addr  <= a_addr;
      sts_lanes <= chk_fail;
    end else if (sts_clr) begin
      sts_valid <= 1'b0;
      sts_addr  <= '0;
      sts_lanes <= '0;
    end

  assign term  = (st == TERM);
  assign rdata = rd_q[31:0];
  assign irq   = sts_valid && irq_en;
endmodule

// File: rtl/parity_mem_ctrl_chk.sv
module parity_mem_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          term,
  input logic          err,
  input logic          irq,
  input logic          sts_clr,
  input logic          sts_valid,
  input logic [AW+1:0] sts_addr,
  input logic [3:0]    sts_lanes
);
  // R12
  term_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) term |=> !term);
  // R12
  term_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(term && err));
  // R10
  err_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> $past(req));
  // R5
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && !sts_clr) |=> (sts_valid && $stable(sts_addr) && $stable(sts_lanes)));
  // R5
  sts_set_after_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_valid) |-> $past(term));
  // R13
  clr_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !term) |=> !irq);
endmodule

bind parity_mem_ctrl parity_mem_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .term(term), .err(err), .irq(irq),
  .sts_clr(sts_clr), .sts_valid(sts_valid), .sts_addr(sts_addr), .sts_lanes(sts_lanes)
);

// File: tb/parity_mem_ctrl_tb.sv
module parity_mem_ctrl_tb;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, inj_par = 1'b0, irq_en = 1'b1, sts_clr = 1'b0;
  logic [AW+1:0] addr = '0;
  logic [1:0] size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic term, err, irq, sts_valid;
  logic [AW+1:0] sts_addr;
  logic [3:0] sts_lanes;

  always #2 clk = ~clk;

  parity_mem_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
    .wdata(wdata), .inj_par(inj_par), .irq_en(irq_en), .sts_clr(sts_clr),
    .rdata(rdata), .term(term), .err(err), .irq(irq), .sts_valid(sts_valid),
    .sts_addr(sts_addr), .sts_lanes(sts_lanes)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] md [NW];
  logic [3:0]  mp [NW];
  logic          m_valid = 0;
  logic [AW+1:0] m_addr = '0;
  logic [3:0]    m_lanes = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] bpar(input logic [31:0] d);
    for (int i = 0; i < 4; i++) bpar[i] = ^d[8*i +: 8];
  endfunction

  function automatic logic [3:0] lanes_of(input logic [1:0] off, input logic [1:0] s);
    logic [3:0] b;
    b = (s == 2'b00) ? 4'b0001 : (s == 2'b01) ? 4'b0011 : 4'b1111;
    return b << off;
  endfunction

  function automatic bit bad_of(input logic [1:0] off, input logic [1:0] s);
    int n;
    n = (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    return (s == 2'b11) || (int'(off) + n > 4);
  endfunction

  task automatic check_status();
    chk(sts_valid == m_valid, "R5 sts_valid", 64'(sts_valid), 64'(m_valid));
    chk(sts_addr == m_addr && sts_lanes == m_lanes, "R4 status addr/lanes",
        {sts_addr, sts_lanes}, {m_addr, m_lanes});
    chk(irq == (m_valid && irq_en), "R6 irq", 64'(irq), 64'(m_valid && irq_en));
  endtask

  task automatic access(input logic w, input logic [AW+1:0] a, input logic [1:0] s,
                        input logic [31:0] d, input logic inj);
    int n, word, lat;
    logic [3:0] ln, fail;
    word = int'(a[AW+1:2]);
    ln = lanes_of(a[1:0], s);
    @(negedge clk);
    req = 1; we = w; addr = a; size = s; wdata = d; inj_par = inj;
    @(negedge clk);
    req = 0; inj_par = 0;
    n = 1;
    while (!term && !err && n < 8) begin @(negedge clk); n++; end
    if (bad_of(a[1:0], s)) begin
      chk(err && !term && n == 1, "R10 err strobe", {32'(n), 31'(0), err}, {32'd1, 32'd1});
    end else begin
      lat = (!w || ln == 4'hF) ? 2 : 3;
      chk(term && n == lat, !w ? "R3 read latency" : (ln == 4'hF ? "R7 full write latency" : "R8 partial write latency"),
          64'(n), 64'(lat));
      if (!w) begin
        chk(rdata == md[word], "R2 rdata", 64'(rdata), 64'(md[word]));
        fail = ln & (mp[word] ^ bpar(md[word]));
        if (fail != 0 && !m_valid) begin
          m_valid = 1; m_addr = a; m_lanes = fail;
        end
      end else begin
        for (int i = 0; i < 4; i++)
          if (ln[i]) begin
            md[word][8*i +: 8] = d[8*i +: 8];
            mp[word][i] = (^d[8*i +: 8]) ^ inj;
          end
      end
    end
    @(negedge clk);
    chk(!term, "R12 term single cycle", 64'(term), 64'd0);
    check_status();
  endtask

  task automatic clear_sts();
    @(negedge clk); sts_clr = 1;
    @(negedge clk); sts_clr = 0;
    m_valid = 0; m_addr = '0; m_lanes = '0;
    chk(!sts_valid && !irq, "R13 clear", {sts_valid, irq}, 64'd0);
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!term && !err && !irq && !sts_valid, "R12 reset outputs", {term, err, irq, sts_valid}, 64'd0);
    rst_n = 1;
    for (int w = 0; w < NW; w++) begin
      md[w] = '0; mp[w] = '0;
      access(1, AW'(w) << 2, 2'b10, $urandom, 0);
    end
    access(0, 6'd0, 2'b10, 0, 0);
    chk(!sts_valid, "R1 clean read no error", 64'(sts_valid), 64'd0);

    access(1, 6'd8, 2'b10, 32'hA1B2C3D4, 1);
    access(1, 6'd8, 2'b00, 32'h000000EE, 0);
    access(0, 6'd8, 2'b00, 0, 0);
    chk(!sts_valid, "R4 unselected bad lanes ignored", 64'(sts_valid), 64'd0);
    chk(rdata == 32'hA1B2C3EE, "R8 untouched bytes kept", 64'(rdata), 64'hA1B2C3EE);
    access(0, 6'd10, 2'b01, 0, 0);
    chk(sts_lanes == 4'b1100 && sts_addr == 6'd10, "R9 injected lanes only", {sts_addr, sts_lanes}, {6'd10, 4'b1100});
    access(0, 6'd9, 2'b00, 0, 0);
    chk(sts_addr == 6'd10, "R5 sticky first error", 64'(sts_addr), 64'd10);
    @(negedge clk); irq_en = 0;
    @(negedge clk);
    chk(!irq, "R6 masked", 64'(irq), 64'd0);
    irq_en = 1;
    @(negedge clk);
    chk(irq, "R6 unmasked", 64'(irq), 64'd1);
    clear_sts();
    access(1, 6'd11, 2'b01, 32'hFFFFFFFF, 0);
    access(1, 6'd13, 2'b11, 32'hFFFFFFFF, 0);
    access(1, 6'd14, 2'b10, 32'hFFFFFFFF, 0);
    access(0, 6'd12, 2'b10, 0, 0);

    // R11: second request during a partial write is ignored
    @(negedge clk);
    req = 1; we = 1; addr = 6'd12; size = 2'b00; wdata = 32'h0000005A;
    @(negedge clk);
    addr = 6'd20; size = 2'b10; wdata = 32'hDEADBEEF;
    @(negedge clk);
    req = 0;
    while (!term) @(negedge clk);
    md[3][7:0] = 8'h5A; mp[3][0] = ^8'h5A;
    @(negedge clk);
    access(0, 6'd20, 2'b10, 0, 0);
    chk(rdata == md[5], "R11 busy request ignored", 64'(rdata), 64'(md[5]));

    for (int k = 0; k < 2500; k++) begin
      logic [AW+1:0] ra;
      logic [1:0] rs;
      ra = AW'($urandom_range(0, NW - 1)) << 2;
      ra[1:0] = 2'($urandom);
      rs = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
      if ($urandom_range(0, 15) == 0) clear_sts();
      if ($urandom_range(0, 15) == 0) begin @(negedge clk); irq_en = ~irq_en; end
      access(1'($urandom), ra, rs, $urandom, $urandom_range(0, 7) == 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule